// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit keeps the register configuration of a vector coprocessor and answers set-length requests from the scalar core during stripmined loops. Software writes a packed configuration word that states how many vector data registers of each element width it needs (64, 32 and 16 bits) and how many predicate registers it needs. From these counts and the fixed capacity of the vector register file, the unit works out the largest vector length the hardware can hold. It keeps that value until the next legal configuration write.

On each loop pass, software asks for the number of elements it still has to process. The unit replies one cycle later with the granted length, which is the smaller of the request and the current maximum, and stores it in its length register. Software subtracts the grant from its remaining count and repeats until nothing is left. A configuration that asks for more registers than exist is refused and flagged. A request made in strict mode that exceeds the maximum is refused and flagged.

Top module: `vlcfg_unit`

## Requirements
- R1: Reset state. While reset is asserted and in the first cycle after it is released, `vl` reads 0, `maxvl` reads 2048, and `grant_valid`, `cfg_bad` and `len_exc` read 0.
- R2: Configuration word layout. `cfg_word` places the 64-bit register count in bits [8:0], the 32-bit count in bits [17:9], the 16-bit count in bits [26:18] and the predicate count in bits [31:27]. A legal write sets `maxvl`, one cycle later, to floor(2048 / W) rounded down to a multiple of 8, where W is the weighted register count. For example, three 64-bit registers give 680.
- R3: Weighting. W = ceil((4·n64 + 2·n32 + n16) / 4): a 32-bit register weighs half of a 64-bit one and a 16-bit register weighs a quarter. When W is 0, `maxvl` is 2048.
- R4: A write whose data register total (n64 + n32 + n16) exceeds 256, or whose predicate count exceeds 16, pulses `cfg_bad` for one cycle on the next cycle. It leaves `maxvl` unchanged.
- R5: A legal configuration write clears `vl` to 0 on the next cycle. `vl` never exceeds `maxvl`.
- R6: A request (`req_valid`) with `req_strict` low yields, on the next cycle, `grant_valid` high and `grant_vl` = min(`req_avl`, `maxvl`). `vl` takes the same value. When the remaining count is below the maximum, the grant equals the remaining count exactly.
- R7: A request with `req_strict` high and `req_avl` > `maxvl` yields, on the next cycle, `len_exc` high, `grant_valid` low and `vl` unchanged.
- R8: When a configuration write and a request arrive in the same cycle, the grant is computed from the maximum in force before the write. A legal write still clears `vl` to 0.
- R9: `grant_valid` is high for exactly one cycle after each request that is not refused, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 32 | Packed register counts (see R2) |
| req_valid | input | 1 | Set-length request strobe |
| req_avl | input | 32 | Requested application vector length |
| req_strict | input | 1 | Refuse, rather than clip, a request above the maximum |
| grant_valid | output | 1 | Granted length is valid |
| grant_vl | output | 12 | Granted vector length |
| vl | output | 12 | Current vector length register |
| maxvl | output | 12 | Current maximum vector length |
| cfg_bad | output | 1 | Illegal configuration pulse |
| len_exc | output | 1 | Strict request over the maximum pulse |

## Verification
The properties assume that `req_valid` and `cfg_we` are driven to 0 during reset, and that the counts in `cfg_word` are ordinary binary values. They also assume that a strict refusal and a grant are never wanted for the same request. The bench holds every strobe low until reset has been released for several cycles. It changes inputs only on the falling clock edge. Its random configuration fields are drawn mostly below the legal limits, with occasional draws above them so that the refusal path is exercised. It covers same-cycle configuration writes and requests on purpose, because there the old and new maximum differ.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  // Default register-file geometry
  localparam int unsigned DEF_BANKS     = 4;
  localparam int unsigned DEF_ENTRIES   = 256;
  localparam int unsigned DEF_BANK_W    = 128;
  localparam int unsigned DEF_ELEM_W    = 64;
  localparam int unsigned DEF_MAX_VREGS = 256;
  localparam int unsigned DEF_MAX_PREGS = 16;
  localparam int unsigned DEF_AVL_W     = 32;

  // Outcome of a set-length request
  typedef enum logic [1:0] {
    REQ_IDLE  = 2'd0,
    REQ_GRANT = 2'd1,
    REQ_REFUSE = 2'd2
  } req_res_e;
endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode #(
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned PCNT_W    = 5,
  parameter int unsigned MAX_VREGS = 256,
  parameter int unsigned MAX_PREGS = 16,
  localparam int unsigned CFG_W    = 3*CNT_W + PCNT_W,
  localparam int unsigned DEN_W    = CNT_W + 1
) (
  input  logic [CFG_W-1:0] cfg_word,
  output logic             legal,
  output logic [DEN_W-1:0] weight
);
  localparam int unsigned DS_W = CNT_W + 2;
  localparam int unsigned WW   = CNT_W + 3;
  localparam logic [DS_W-1:0]   VREG_LIM = DS_W'(MAX_VREGS);
  localparam logic [PCNT_W-1:0] PREG_LIM = PCNT_W'(MAX_PREGS);

  logic [CNT_W-1:0]  n64, n32, n16;
  logic [PCNT_W-1:0] npr;
  logic [DS_W-1:0]   dsum;
  logic [WW-1:0]     quarters;
  logic [WW-1:0]     rounded;

  always_comb begin
    n64 = cfg_word[CNT_W-1:0];
    n32 = cfg_word[2*CNT_W-1:CNT_W];
    n16 = cfg_word[3*CNT_W-1:2*CNT_W];
    npr = cfg_word[CFG_W-1:3*CNT_W];
    dsum = {2'b00, n64} + {2'b00, n32} + {2'b00, n16};
    legal = (dsum <= VREG_LIM) && (npr <= PREG_LIM);
    // Weight in quarter-register units, then ceiling to whole registers
    quarters = {1'b0, n64, 2'b00} + {2'b00, n32, 1'b0} + {3'b000, n16};
    rounded  = quarters + WW'(3);
    weight   = rounded[WW-1:2];
  end
endmodule

// File: rtl/vlcfg_divider.sv
module vlcfg_divider #(
  parameter int unsigned SLOTS = 2048,
  parameter int unsigned GRAN  = 8,
  parameter int unsigned DEN_W = 10,
  localparam int unsigned VL_W = $clog2(SLOTS + 1)
) (
  input  logic [DEN_W-1:0] den,
  output logic [VL_W-1:0]  maxvl
);
  localparam int unsigned RW     = DEN_W + 1;
  localparam int unsigned GRAN_LG = $clog2(GRAN);
  localparam logic [VL_W-1:0] NUM = VL_W'(SLOTS);

  logic [RW-1:0]   rem;
  logic [VL_W-1:0] quo;

  // Restoring division of the fixed slot count by the weight
  always_comb begin
    rem = '0;
    quo = '0;
    for (int i = VL_W - 1; i >= 0; i--) begin
      rem = {rem[RW-2:0], NUM[i]};
      if (rem >= {1'b0, den}) begin
        rem    = rem - {1'b0, den};
        quo[i] = 1'b1;
      end
    end
    if (den == '0) maxvl = NUM;
    else           maxvl = {quo[VL_W-1:GRAN_LG], {GRAN_LG{1'b0}}};
  end
endmodule

// File: rtl/vlcfg_grant.sv
module vlcfg_grant
  import vlcfg_pkg::*;
#(
  parameter int unsigned AVL_W = 32,
  parameter int unsigned VL_W  = 12
) (
  input  logic             req_valid,
  input  logic [AVL_W-1:0] req_avl,
  input  logic             req_strict,
  input  logic [VL_W-1:0]  maxvl,
  output req_res_e         res,
  output logic [VL_W-1:0]  gvl
);
  logic over;
  always_comb begin
    over = req_avl > {{(AVL_W-VL_W){1'b0}}, maxvl};
    gvl  = over ? maxvl : req_avl[VL_W-1:0];
    if (!req_valid)          res = REQ_IDLE;
    else if (over && req_strict) res = REQ_REFUSE;
    else                     res = REQ_GRANT;
  end
endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int unsigned BANKS     = DEF_BANKS,
  parameter int unsigned ENTRIES   = DEF_ENTRIES,
  parameter int unsigned BANK_W    = DEF_BANK_W,
  parameter int unsigned ELEM_W    = DEF_ELEM_W,
  parameter int unsigned MAX_VREGS = DEF_MAX_VREGS,
  parameter int unsigned MAX_PREGS = DEF_MAX_PREGS,
  parameter int unsigned AVL_W     = DEF_AVL_W,
  localparam int unsigned SLOTS    = BANKS * ENTRIES * BANK_W / ELEM_W,
  localparam int unsigned GRAN     = BANKS * BANK_W / ELEM_W,
  localparam int unsigned VL_W     = $clog2(SLOTS + 1),
  localparam int unsigned CNT_W    = $clog2(MAX_VREGS + 1),
  localparam int unsigned PCNT_W   = $clog2(MAX_PREGS + 1),
  localparam int unsigned CFG_W    = 3*CNT_W + PCNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             req_valid,
  input  logic [AVL_W-1:0] req_avl,
  input  logic             req_strict,
  output logic             grant_valid,
  output logic [VL_W-1:0]  grant_vl,
  output logic [VL_W-1:0]  vl,
  output logic [VL_W-1:0]  maxvl,
  output logic             cfg_bad,
  output logic             len_exc
);
  localparam int unsigned DEN_W = CNT_W + 1;
  localparam logic [VL_W-1:0] SLOTS_V = VL_W'(SLOTS);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic             cfg_legal;
  logic [DEN_W-1:0] weight;
  logic [VL_W-1:0]  new_max;
  req_res_e         res;
  logic [VL_W-1:0]  gvl;

  vlcfg_decode #(
    .CNT_W(CNT_W), .PCNT_W(PCNT_W),
    .MAX_VREGS(MAX_VREGS), .MAX_PREGS(MAX_PREGS)
  ) u_dec (
    .cfg_word(cfg_word), .legal(cfg_legal), .weight(weight)
  );

  vlcfg_divider #(
    .SLOTS(SLOTS), .GRAN(GRAN), .DEN_W(DEN_W)
  ) u_div (
    .den(weight), .maxvl(new_max)
  );

  vlcfg_grant #(
    .AVL_W(AVL_W), .VL_W(VL_W)
  ) u_grt (
    .req_valid(req_valid), .req_avl(req_avl), .req_strict(req_strict),
    .maxvl(maxvl), .res(res), .gvl(gvl)
  );

  // Next state
  logic            max_en, vl_en, gvl_en;
  logic [VL_W-1:0] max_d, vl_d;
  logic            gv_d, bad_d, exc_d;

  always_comb begin
    max_en = cfg_we && cfg_legal;
    max_d  = new_max;
    gvl_en = (res == REQ_GRANT);
    gv_d   = (res == REQ_GRANT);
    exc_d  = (res == REQ_REFUSE);
    bad_d  = cfg_we && !cfg_legal;
    vl_en  = max_en || gvl_en;
    vl_d   = max_en ? '0 : gvl;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      maxvl       <= SLOTS_V;
      vl          <= '0;
      grant_vl    <= '0;
      grant_valid <= 1'b0;
      cfg_bad     <= 1'b0;
      len_exc     <= 1'b0;
    end else begin
      if (max_en) maxvl    <= max_d;
      if (vl_en)  vl       <= vl_d;
      if (gvl_en) grant_vl <= gvl;
      grant_valid <= gv_d;
      cfg_bad     <= bad_d;
      len_exc     <= exc_d;
    end
  end
endmodule

// File: rtl/vlcfg_unit_chk.sv
module vlcfg_unit_chk #(
  parameter int unsigned VL_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            req_valid,
  input logic            grant_valid,
  input logic [VL_W-1:0] grant_vl,
  input logic [VL_W-1:0] vl,
  input logic [VL_W-1:0] maxvl,
  input logic            cfg_bad,
  input logic            len_exc
);
  p_grant_le_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant_vl <= $past(maxvl));

  p_grant_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $past(req_valid));

  p_bad_keeps_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> $stable(maxvl));

  p_refuse_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    len_exc |-> !grant_valid);

  p_vl_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vl <= maxvl);

  p_cfg_clears_vl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && !cfg_bad) |-> vl == '0);
endmodule

bind vlcfg_unit vlcfg_unit_chk #(.VL_W(VL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .req_valid(req_valid),
  .grant_valid(grant_valid), .grant_vl(grant_vl), .vl(vl), .maxvl(maxvl),
  .cfg_bad(cfg_bad), .len_exc(len_exc)
);

// File: tb/sim_vlcfg_unit.sv
module sim_vlcfg_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_word;
  logic        req_valid;
  logic [31:0] req_avl;
  logic        req_strict;
  logic        grant_valid;
  logic [11:0] grant_vl, vl, maxvl;
  logic        cfg_bad, len_exc;

  int n_tests = 0;
  int n_fail  = 0;
  int m_max, m_vl;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlcfg_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_avl(req_avl), .req_strict(req_strict),
    .grant_valid(grant_valid), .grant_vl(grant_vl), .vl(vl), .maxvl(maxvl),
    .cfg_bad(cfg_bad), .len_exc(len_exc)
  );

  function automatic logic [31:0] pack(int a, int b, int c, int p);
    logic [8:0] a9, b9, c9;
    logic [4:0] p5;
    a9 = 9'(a); b9 = 9'(b); c9 = 9'(c); p5 = 5'(p);
    return {p5, c9, b9, a9};
  endfunction

  function automatic int exp_max(int a, int b, int c);
    int w;
    w = (4*a + 2*b + c + 3) / 4;
    if (w == 0) return 2048;
    return ((2048 / w) / 8) * 8;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle of stimulus, checked against the model after the edge
  task automatic step(input bit we, input int a, input int b, input int c, input int p,
                      input bit rq, input int avl, input bit st, input string tag);
    bit legal, exc, gv, bad;
    int g, nvl, nmax;
    @(negedge clk);
    cfg_we = we; cfg_word = pack(a, b, c, p);
    req_valid = rq; req_avl = avl; req_strict = st;
    legal = (a + b + c <= 256) && (p <= 16);
    bad   = we && !legal;
    g     = (avl > m_max) ? m_max : avl;
    exc   = rq && st && (avl > m_max);
    gv    = rq && !exc;
    nmax  = (we && legal) ? exp_max(a, b, c) : m_max;
    nvl   = (we && legal) ? 0 : (gv ? g : m_vl);
    @(posedge clk);
    #1;
    chk(maxvl == 12'(nmax), {tag, " maxvl"}, maxvl, nmax);
    chk(vl == 12'(nvl), {tag, " vl"}, vl, nvl);
    chk(grant_valid == gv, {tag, " grant_valid"}, grant_valid, gv);
    if (gv) chk(grant_vl == 12'(g), {tag, " grant_vl"}, grant_vl, g);
    chk(cfg_bad == bad, {tag, " cfg_bad"}, cfg_bad, bad);
    chk(len_exc == exc, {tag, " len_exc"}, len_exc, exc);
    m_max = nmax; m_vl = nvl;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int rem, r;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_word = '0;
    req_valid = 1'b0; req_avl = '0; req_strict = 1'b0;
    m_max = 2048; m_vl = 0;
    r = $urandom(1234);
    repeat (3) @(posedge clk);
    #1;
    chk(vl == 0 && maxvl == 2048, "R1 in reset", maxvl, 2048);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(vl == 0, "R1 vl", vl, 0);
    chk(maxvl == 2048, "R1 maxvl", maxvl, 2048);
    chk(!grant_valid && !cfg_bad && !len_exc, "R1 flags", grant_valid, 0);

    // R3 empty configuration keeps the full capacity; grant clipped (R6)
    step(0,0,0,0,0, 1, 5000, 0, "R3/R6 full");
    // R2 three 64-bit registers -> 680
    step(1,3,0,0,1, 0, 0, 0, "R2 three64");
    chk(maxvl == 680, "R2 value 680", maxvl, 680);
    // R3 weighting cases
    step(1,0,3,0,0, 0, 0, 0, "R3 three32");
    step(1,0,0,1,0, 0, 0, 0, "R3 one16");
    step(1,1,1,0,2, 0, 0, 0, "R3 mix");
    step(1,5,0,0,0, 0, 0, 0, "R3 five64");
    step(1,256,0,0,16, 0, 0, 0, "R3 max legal");
    // R4 illegal configurations
    step(1,3,0,0,0, 1, 100, 0, "R5 setup");
    step(1,1,1,1,17, 0, 0, 0, "R4 too many preds");
    step(1,200,57,0,0, 0, 0, 0, "R4 too many regs");
    // R5 legal write clears vl
    step(0,0,0,0,0, 1, 300, 0, "R6 grant");
    step(1,2,2,2,4, 0, 0, 0, "R5 clear");
    // R6 stripmine with 680
    step(1,3,0,0,1, 0, 0, 0, "R6 setup");
    rem = 2000;
    while (rem > 0) begin
      step(0,0,0,0,0, 1, rem, 0, "R6 stripmine");
      if (rem < 680) chk(grant_vl == 12'(rem), "R6 tail exact", grant_vl, rem);
      rem -= (rem > 680) ? 680 : rem;
    end
    // R7 strict refusal; boundary at exactly maxvl is granted
    step(0,0,0,0,0, 1, 681, 1, "R7 strict over");
    step(0,0,0,0,0, 1, 680, 1, "R7 strict equal");
    // R8 same-cycle write and request
    step(1,1,0,0,0, 1, 1500, 0, "R8 same cycle");
    step(1,0,0,0,0, 1, 4000, 0, "R8 same cycle 2");
    // R9 no request, no grant
    step(0,0,0,0,0, 0, 7, 0, "R9 idle");

    for (int i = 0; i < 400; i++) begin
      bit we, rq, st;
      int a, b, c, p;
      we = ($urandom % 6) == 0;
      rq = ($urandom % 2) == 0;
      st = ($urandom % 4) == 0;
      a = $urandom % 10; b = $urandom % 10; c = $urandom % 10;
      if (($urandom % 10) == 0) a = 200 + ($urandom % 70);
      p = $urandom % 19;
      step(we, a, b, c, p, rq, $urandom % 3000, st, "R2-R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule